// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Decoder

This block turns a stream of run-length bytes from an infrared receiver front end into one 32-bit remote-control code per frame. Each byte carries a level bit and a duration in sample ticks of about 42.7 µs. Consecutive bytes of the same level are merged into a single run. The decoder first looks for a long leading mark followed by a long leading space. It then times the mark and the space of each bit, with the space length deciding the bit value, and collects 32 bits with the least significant bit first.

A frame-end strobe closes the frame. One clock later the block presents the code together with a one-cycle valid or error flag. A frame is valid only when the command byte and its inverted copy agree; the address bytes are passed through unchecked. Timing faults make the code read all ones.

Top module: `ir_pd_decoder`

## Requirements
- R1: After reset, out_code is 0, out_valid and out_err are 0, and in_ready is 1.
- R2: Input bytes use bit 7 as the level (1 = mark, 0 = space) and bits 6:0 as a tick count; bytes of the same level add into one run. The leading-mark run starts at 64 ticks for the first mark of a frame. It is accepted when its total exceeds 80 when the first space arrives. A shorter mark is discarded, its run restarts at 0, and the search continues.
- R3: The leading space run must exceed 40 ticks when the next mark arrives. Otherwise the frame is in error.
- R4: A bit mark run longer than 26 ticks is an error.
- R5: A bit space run longer than 53 ticks is an error. A run from 27 to 53 ticks decodes as 1, and a run of 26 ticks or less decodes as 0.
- R6: Decoded bits fill out_code from bit 0 upward. Decoding stops after the 32nd bit, and later bytes in the same frame have no effect.
- R7: A frame with a timing error, or with fewer than 32 bits at frame end, yields out_code = 0xFFFFFFFF and out_err = 1.
- R8: A complete frame is valid only when bits 23:16 equal the bitwise inverse of bits 31:24. Bits 15:0 are not checked. A frame that fails this check shows the decoded code with out_err = 1 and out_valid = 0.
- R9: out_valid or out_err is high for exactly the one cycle after frame_end, never both at once. in_ready is 0 while frame_end is high, and a frame end restarts the search for a new leader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Run byte: level in bit 7, ticks in bits 6:0 |
| in_valid | input | 1 | in_data is present |
| in_ready | output | 1 | Byte accepted when in_valid is also high |
| frame_end | input | 1 | Closes the current frame |
| out_code | output | 32 | Decoded code, or all ones on a timing error |
| out_valid | output | 1 | One-cycle pulse: frame decoded and command check passed |
| out_err | output | 1 | One-cycle pulse: frame rejected |

## Verification
The hardest situation to reach is a threshold being crossed by a merged run rather than by a single byte. Examples are a leading mark split across two bytes after a discarded short mark, or a bit mark built from two bytes that sums exactly to the limit. The stimulus builds frames byte by byte with chosen mark and space lengths. It places runs at each limit and one tick past it (40/41, 26/27, 53/54, and 16/17 against the 64-tick starting offset). It also sends a 20-bit frame and trailing bytes after the 32nd bit.

// File: rtl/ir_pd_decoder.sv
module ir_pd_decoder #(
  parameter int LEN_W      = 12,
  parameter int LEAD_M_MIN = 80,
  parameter int LEAD_S_MIN = 40,
  parameter int MARK_MAX   = 26,
  parameter int SPACE_MID  = 26,
  parameter int SPACE_MAX  = 53,
  parameter int ACT_T      = 0,
  parameter bit ACT_SCALE  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        frame_end,
  output logic [31:0] out_code,
  output logic        out_valid,
  output logic        out_err
);
  localparam int CODE_W   = 32;
  localparam int CNT_W    = $clog2(CODE_W + 1);
  localparam int INIT_LEN = ((ACT_T + 1) * (ACT_SCALE ? 128 : 1)) >> 1;
  localparam logic [LEN_W-1:0] LEN_INIT = LEN_W'(INIT_LEN);
  localparam logic [LEN_W-1:0] LEN_MAX  = '1;

  typedef enum logic [2:0] {S_LMARK, S_LSPACE, S_BMARK, S_BSPACE, S_DONE, S_ERR} st_t;

  st_t               st;
  logic [LEN_W-1:0]  len;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] acc;

  logic             is_mark;
  logic [LEN_W-1:0] dur;
  logic [LEN_W:0]   sum_raw;
  logic [LEN_W-1:0] sum;
  logic             take;
  logic             cmd_ok;

  assign in_ready = !frame_end;
  assign take     = in_valid && !frame_end;
  assign is_mark  = in_data[7];
  assign dur      = LEN_W'(in_data[6:0]);
  assign sum_raw  = {1'b0, len} + {1'b0, dur};
  assign sum      = sum_raw[LEN_W] ? LEN_MAX : sum_raw[LEN_W-1:0];
  assign cmd_ok   = acc[23:16] == ~acc[31:24];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_LMARK;
      len       <= LEN_INIT;
      cnt       <= '0;
      acc       <= '0;
      out_code  <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      if (frame_end) begin
        if (st == S_DONE) begin
          out_code  <= acc;
          out_valid <= cmd_ok;
          out_err   <= !cmd_ok;
        end else begin
          out_code <= '1;
          out_err  <= 1'b1;
        end
        st  <= S_LMARK;
        len <= LEN_INIT;
        cnt <= '0;
        acc <= '0;
      end else if (take) begin
        case (st)
          S_LMARK:
            if (is_mark) len <= sum;
            else if (len > LEN_W'(LEAD_M_MIN)) begin
              st  <= S_LSPACE;
              len <= dur;
            end else len <= '0;
          S_LSPACE:
            if (!is_mark) len <= sum;
            else if (len > LEN_W'(LEAD_S_MIN)) begin
              st  <= S_BMARK;
              len <= dur;
            end else st <= S_ERR;
          S_BMARK:
            if (is_mark) len <= sum;
            else if (len > LEN_W'(MARK_MAX)) st <= S_ERR;
            else begin
              st  <= S_BSPACE;
              len <= dur;
            end
          S_BSPACE:
            if (!is_mark) len <= sum;
            else if (len > LEN_W'(SPACE_MAX)) st <= S_ERR;
            else begin
              acc[cnt[4:0]] <= len > LEN_W'(SPACE_MID);
              cnt           <= cnt + 1'b1;
              st            <= (cnt == CNT_W'(CODE_W - 1)) ? S_DONE : S_BMARK;
              len           <= dur;
            end
          default: ;
        endcase
      end
    end
  end

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_err));

  assert_flag_follows_end_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_err) |-> $past(frame_end));

  assert_cmd_pair_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code[23:16] == ~out_code[31:24]));

  assert_bit_limit_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CODE_W));

  assert_err_all_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (out_err && $past(st) != S_DONE) |-> (out_code == '1));

endmodule

// File: tb/sim_ir_pd_decoder.sv
module sim_ir_pd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        frame_end = 1'b0;
  logic        in_ready;
  logic [31:0] out_code;
  logic        out_valid;
  logic        out_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ir_pd_decoder u0 (.clk, .rst, .in_data, .in_valid, .in_ready, .frame_end,
                    .out_code, .out_valid, .out_err);

  localparam int NV = 5;
  localparam logic [31:0] VEC [NV] = '{32'hF20D1234, 32'h00FFAA55, 32'hFF000000,
                                       32'h12345678, 32'hA55A0000};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input bit lvl, input int ticks);
    in_data  = {lvl, 7'(ticks)};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic end_frame(input string tag, input bit timing_ok, input logic [31:0] c);
    logic ev;
    ev = c[23:16] == ~c[31:24];
    frame_end = 1'b1;
    #1;
    chk({tag, " R9 ready low"}, 32'(in_ready), 32'd0);
    @(negedge clk);
    frame_end = 1'b0;
    if (timing_ok) begin
      chk({tag, " code"}, out_code, c);
      chk({tag, " R8 valid"}, 32'(out_valid), 32'(ev));
      chk({tag, " R8 err"}, 32'(out_err), 32'(!ev));
    end else begin
      chk({tag, " R7 code"}, out_code, 32'hFFFFFFFF);
      chk({tag, " R7 valid"}, 32'(out_valid), 32'd0);
      chk({tag, " R7 err"}, 32'(out_err), 32'd1);
    end
    @(negedge clk);
    chk({tag, " R9 pulse ends"}, 32'(out_valid | out_err), 32'd0);
  endtask

  task automatic frame(input logic [31:0] c, input int lm, input int ls, input int mk,
                       input int sp0, input int sp1, input int nbits, input bit extra);
    send(1'b1, lm);
    send(1'b0, ls);
    for (int i = 0; i < nbits; i++) begin
      send(1'b1, mk);
      send(1'b0, c[i] ? sp1 : sp0);
    end
    send(1'b1, mk);
    if (extra) begin
      send(1'b0, 60);
      send(1'b1, 40);
      send(1'b0, 100);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 code", out_code, 32'd0);
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 err", 32'(out_err), 32'd0);
    chk("R1 ready", 32'(in_ready), 32'd1);

    for (int v = 0; v < NV; v++) begin
      frame(VEC[v], 100, 60, 13, 13, 39, 32, 1'b0);
      end_frame("R5 R6 table", 1'b1, VEC[v]);
    end

    // R2: short mark discarded, then leader merged from two bytes
    send(1'b1, 5); send(1'b0, 5); send(1'b1, 60);
    frame(32'hF20D0001, 30, 60, 13, 13, 39, 32, 1'b0);
    end_frame("R2 merged lead", 1'b1, 32'hF20D0001);
    // R2: starting offset 64, 17 passes, 16 does not
    frame(32'h00FF0F0F, 17, 60, 13, 13, 39, 32, 1'b0);
    end_frame("R2 offset 81", 1'b1, 32'h00FF0F0F);
    frame(32'h00FF0F0F, 16, 60, 13, 13, 39, 32, 1'b0);
    end_frame("R2 offset 80", 1'b0, 32'h0);
    // R3
    frame(32'h807F1111, 100, 41, 13, 13, 39, 32, 1'b0);
    end_frame("R3 space 41", 1'b1, 32'h807F1111);
    frame(32'h807F1111, 100, 40, 13, 13, 39, 32, 1'b0);
    end_frame("R3 space 40", 1'b0, 32'h0);
    // R4: merged mark of 26 passes, 27 fails
    send(1'b1, 100); send(1'b0, 60);
    for (int i = 0; i < 32; i++) begin
      send(1'b1, 13); send(1'b1, 13); send(1'b0, 39);
    end
    send(1'b1, 13);
    end_frame("R4 mark 26", 1'b1, 32'hFFFFFFFF ^ 32'h0 ^ 32'h0);
    frame(32'h00FF0000, 100, 60, 27, 13, 39, 32, 1'b0);
    end_frame("R4 mark 27", 1'b0, 32'h0);
    // R5 boundaries
    frame(32'hC33C5A5A, 100, 60, 13, 26, 27, 32, 1'b0);
    end_frame("R5 26/27", 1'b1, 32'hC33C5A5A);
    frame(32'hC33C5A5A, 100, 60, 13, 26, 53, 32, 1'b0);
    end_frame("R5 space 53", 1'b1, 32'hC33C5A5A);
    frame(32'hC33C5A5A, 100, 60, 13, 26, 54, 32, 1'b0);
    end_frame("R5 space 54", 1'b0, 32'h0);
    // R6: trailing bytes after 32 bits ignored
    frame(32'h01FE8001, 100, 60, 13, 13, 39, 32, 1'b1);
    end_frame("R6 trailing", 1'b1, 32'h01FE8001);
    // R7: short frame
    frame(32'h00FF0000, 100, 60, 13, 13, 39, 20, 1'b0);
    end_frame("R7 20 bits", 1'b0, 32'h0);
    // R7: frame end with nothing received
    end_frame("R7 empty", 1'b0, 32'h0);
    // R8: command mismatch, address differs but unchecked
    frame(32'h55AB9999, 100, 60, 13, 13, 39, 32, 1'b0);
    end_frame("R8 mismatch", 1'b1, 32'h55AB9999);
    frame(32'h55AA9999, 100, 60, 13, 13, 39, 32, 1'b0);
    end_frame("R8 match", 1'b1, 32'h55AA9999);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule